// File: doc/BRIEF.md
# Pipelined Every-Nth Packet Sampler

This block sits in a packet header pipeline and picks one packet out of every ten for sampling. It accepts one header per clock cycle, qualified by a valid strobe. Each header carries a 32-bit source address and a bundle of other header bits. Every header leaves the block exactly two cycles later with a sample field added. For a picked packet, the sample field holds that packet's source address. For every other packet, it holds zero.

The block keeps one persistent modulo counter. The first stage is the only stateful one. In a single cycle it reads the counter, decides whether this packet is the picked one, and writes the next counter value back. Back-to-back packets therefore never see a stale count. The decision travels with the packet as a one-bit flag. The second stage is purely stateless and builds the sample field from that flag and the carried source address. Idle cycles pass through as bubbles and do not consume a count.

Top module: `every_nth_sampler`

## Requirements
- R1: A synchronous active-low reset clears the counter to zero and invalidates both pipeline stages. After reset, out_valid is 0 and the tenth valid packet that follows is the first one picked.
- R2: The counter advances only on cycles with in_valid high. It steps 0,1,…,9 and then returns to 0.
- R3: A valid packet that arrives while the counter holds 9 (the 10th, 20th, … valid packet since reset) leaves with out_sample equal to its own in_src.
- R4: Every other valid packet leaves with out_sample equal to 0.
- R5: out_valid equals in_valid from exactly two clock edges earlier.
- R6: out_src and out_meta equal the in_src and in_meta presented two clock edges earlier, unchanged.
- R7: Idle cycles (in_valid low) do not shift the sampling position. Only valid packets are counted.
- R8: The block accepts a valid packet on every cycle with no stall, and a continuous input burst yields a continuous output burst.
- R9: The sampling period repeats after the wrap. Following a picked packet, the next nine valid packets get 0 and the tenth after it is picked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Header present this cycle |
| in_src | input | 32 | Source address of the incoming header |
| in_meta | input | 16 | Other header bits, carried through |
| out_valid | output | 1 | Header present on the outputs |
| out_src | output | 32 | Source address, delayed by two cycles |
| out_meta | output | 16 | Other header bits, delayed by two cycles |
| out_sample | output | 32 | Source address if the packet is picked, else 0 |

## Verification
Each of the four outputs is due two rising edges after the cycle in which its header was driven. That covers valid, source, other header bits and sample. The bench drives inputs on the falling edge and keeps a two-entry shift of expected outputs. At each falling edge, before it drives new inputs, it compares the ports against the entry that has aged two steps. The expected sample comes from a bench count of valid packets since the last reset: a packet is picked when that count is a multiple of ten. A reset step clears both shift entries, which matches a synchronous reset of both stages on the next edge.

// File: rtl/sampler_pkg.sv
// Package: shared defaults and a helper for the every-Nth sampler.
// Assumes: the sampling period is at least 2.
package sampler_pkg;
    parameter int unsigned DEF_SRC_W  = 32;
    parameter int unsigned DEF_META_W = 16;
    parameter int unsigned DEF_PERIOD = 10;

    // Width needed to hold count values 0 .. period-1
    function automatic int unsigned count_width(input int unsigned period);
        return (period < 2) ? 1 : $clog2(period);
    endfunction
endpackage

// File: rtl/sample_count_stage.sv
// Module: stage 1, the only stateful stage.
// Reads the modulo counter, flags the packet that sees the last count,
// and writes the next count back, all in one cycle so a new packet can
// enter every clock. Header fields are registered alongside the flag.
// Assumes: PERIOD >= 2; the counter moves only on valid cycles.
module sample_count_stage #(
    parameter int unsigned SRC_W  = 32,
    parameter int unsigned META_W = 16,
    parameter int unsigned PERIOD = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [META_W-1:0] in_meta,
    output logic              s1_valid,
    output logic [SRC_W-1:0]  s1_src,
    output logic [META_W-1:0] s1_meta,
    output logic              s1_pick
);
    localparam int unsigned CW = sampler_pkg::count_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] count_q;
    logic          at_last;
    logic [CW-1:0] count_next;

    // Decide whether this packet is picked and what the counter becomes
    always_comb begin
        at_last    = (count_q == LAST);
        count_next = at_last ? '0 : count_q + CW'(1);
    end

    // Persistent counter: read-compare-update on valid cycles only
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (in_valid)
            count_q <= count_next;
    end

    // Valid bit of the stage register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_valid <= 1'b0;
        else
            s1_valid <= in_valid;
    end

    // Payload and pick flag carried forward with the packet
    always_ff @(posedge clk) begin
        s1_src  <= in_src;
        s1_meta <= in_meta;
        s1_pick <= in_valid & at_last;
    end
endmodule

// File: rtl/sample_pick_stage.sv
// Module: stage 2, stateless.
// Builds the sample field from the carried pick flag and source address
// and registers the packet onto the block outputs.
// Assumes: the pick flag is only set for valid packets.
module sample_pick_stage #(
    parameter int unsigned SRC_W  = 32,
    parameter int unsigned META_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [SRC_W-1:0]  s1_src,
    input  logic [META_W-1:0] s1_meta,
    input  logic              s1_pick,
    output logic              out_valid,
    output logic [SRC_W-1:0]  out_src,
    output logic [META_W-1:0] out_meta,
    output logic [SRC_W-1:0]  out_sample
);
    logic [SRC_W-1:0] sample_d;

    // Select the source address for a picked packet, zero otherwise
    always_comb sample_d = s1_pick ? s1_src : '0;

    // Output valid bit, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= s1_valid;
    end

    // Output payload registers
    always_ff @(posedge clk) begin
        out_src    <= s1_src;
        out_meta   <= s1_meta;
        out_sample <= sample_d;
    end
endmodule

// File: rtl/every_nth_sampler.sv
// Module: top of the two-stage every-Nth sampler.
// Stage 1 owns the counter; stage 2 forms the sample field.
// Latency is two cycles and throughput one packet per cycle.
// Assumes: a synchronous active-low reset.
module every_nth_sampler #(
    parameter int unsigned SRC_W  = sampler_pkg::DEF_SRC_W,
    parameter int unsigned META_W = sampler_pkg::DEF_META_W,
    parameter int unsigned PERIOD = sampler_pkg::DEF_PERIOD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [META_W-1:0] in_meta,
    output logic              out_valid,
    output logic [SRC_W-1:0]  out_src,
    output logic [META_W-1:0] out_meta,
    output logic [SRC_W-1:0]  out_sample
);
    logic              s1_valid;
    logic [SRC_W-1:0]  s1_src;
    logic [META_W-1:0] s1_meta;
    logic              s1_pick;

    sample_count_stage #(.SRC_W(SRC_W), .META_W(META_W), .PERIOD(PERIOD)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_src   (in_src),
        .in_meta  (in_meta),
        .s1_valid (s1_valid),
        .s1_src   (s1_src),
        .s1_meta  (s1_meta),
        .s1_pick  (s1_pick)
    );

    sample_pick_stage #(.SRC_W(SRC_W), .META_W(META_W)) u_stage2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_src     (s1_src),
        .s1_meta    (s1_meta),
        .s1_pick    (s1_pick),
        .out_valid  (out_valid),
        .out_src    (out_src),
        .out_meta   (out_meta),
        .out_sample (out_sample)
    );
endmodule

// File: rtl/every_nth_sampler_chk.sv
// Module: assertion checker bound to every_nth_sampler.
// Keeps its own count of valid packets and a two-deep pick pipeline,
// and relates them to the ports and the stage 1 counter.
module every_nth_sampler_chk #(
    parameter int unsigned SRC_W  = 32,
    parameter int unsigned PERIOD = 10,
    parameter int unsigned CW     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SRC_W-1:0] in_src,
    input logic             out_valid,
    input logic [SRC_W-1:0] out_src,
    input logic [SRC_W-1:0] out_sample,
    input logic [CW-1:0]    cnt
);
    logic [1:0]  warm_q;
    int unsigned mdl_cnt;
    logic        mdl_pick1, mdl_pick2;

    // Cycles since reset, saturating at 2
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= 2'd0;
        else if (warm_q != 2'd2)
            warm_q <= warm_q + 2'd1;
    end

    // Independent model of which packets are picked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdl_cnt   <= 0;
            mdl_pick1 <= 1'b0;
            mdl_pick2 <= 1'b0;
        end else begin
            if (in_valid)
                mdl_cnt <= (mdl_cnt == PERIOD - 1) ? 0 : mdl_cnt + 1;
            mdl_pick1 <= in_valid && (mdl_cnt == PERIOD - 1);
            mdl_pick2 <= mdl_pick1;
        end
    end

    a_r1_reset_clears_valid: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && cnt == '0));

    a_r2_count_holds_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt));

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < PERIOD);

    a_r3_picked_carries_src: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mdl_pick2) |-> out_sample == out_src);

    a_r4_unpicked_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mdl_pick2) |-> out_sample == '0);

    a_r5_valid_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> out_valid == $past(in_valid, 2));

    a_r6_src_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid) |-> out_src == $past(in_src, 2));
endmodule

bind every_nth_sampler every_nth_sampler_chk #(
    .SRC_W  (SRC_W),
    .PERIOD (PERIOD),
    .CW     (sampler_pkg::count_width(PERIOD))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_src     (in_src),
    .out_valid  (out_valid),
    .out_src    (out_src),
    .out_sample (out_sample),
    .cnt        (u_stage1.count_q)
);

// File: tb/every_nth_sampler_bench.sv
// Bench: drives sweeps of back-to-back, gapped and reset-interrupted
// traffic and checks every output cycle against a two-step expected shift.
module every_nth_sampler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_src = '0;
    logic [15:0] in_meta = '0;
    logic        out_valid;
    logic [31:0] out_src;
    logic [15:0] out_meta;
    logic [31:0] out_sample;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // expected shift: index 1 is due at the ports on the coming compare
    logic        e_v   [2];
    logic [31:0] e_src [2];
    logic [15:0] e_meta[2];
    logic [31:0] e_smp [2];
    int          nvalid = 0;
    bit          armed = 0;

    always #5 clk = ~clk;

    every_nth_sampler u_every_nth_sampler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_meta(in_meta), .out_valid(out_valid), .out_src(out_src),
        .out_meta(out_meta), .out_sample(out_sample)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: compare aged expectation, then drive and push new one
    task automatic step(input bit rst, input bit v, input logic [31:0] src,
                        input logic [15:0] meta, input string phase);
        @(negedge clk);
        if (armed) begin
            chk(out_valid == e_v[1], {"R5 valid ", phase}, 32'(out_valid), 32'(e_v[1]));
            if (e_v[1]) begin
                chk(out_src == e_src[1], {"R6 src ", phase}, out_src, e_src[1]);
                chk(out_meta == e_meta[1], {"R6 meta ", phase}, 32'(out_meta), 32'(e_meta[1]));
                chk(out_sample == e_smp[1],
                    {(e_smp[1] != 0) ? "R3 picked " : "R4 unpicked ", phase},
                    out_sample, e_smp[1]);
            end
        end
        armed = 1;
        rst_n = !rst; in_valid = v; in_src = src; in_meta = meta;
        if (rst) begin
            nvalid = 0;
            e_v[0] = 0; e_v[1] = 0;
        end else begin
            e_v[1] = e_v[0]; e_src[1] = e_src[0]; e_meta[1] = e_meta[0]; e_smp[1] = e_smp[0];
            e_v[0] = v; e_src[0] = src; e_meta[0] = meta; e_smp[0] = 0;
            if (v) begin
                nvalid++;
                if (nvalid % 10 == 0) e_smp[0] = src;
            end
        end
    endtask

    initial begin
        e_v[0] = 0; e_v[1] = 0;
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "reset");
        step(0, 0, 0, 0, "idle");
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 0);
        // R8 and R9: a continuous burst of 25, picks at 10 and 20
        for (int i = 1; i <= 25; i++)
            step(0, 1, 32'hA000_0000 + 32'(i), 16'(i * 3), "R8 R9 burst");
        // R7 and R2: gapped traffic, every third cycle idle
        for (int i = 0; i < 45; i++)
            step(0, (i % 3) != 0, 32'hB000_0000 + 32'(i * 7), 16'(16'hFFFF - i), "R7 R2 gaps");
        // R1: reset in the middle of a period, then restart counting
        for (int i = 0; i < 4; i++)
            step(0, 1, 32'hC000_0000 + 32'(i), 16'(i), "pre-reset");
        step(1, 1, 32'hDEAD_BEEF, 16'h1234, "R1 reset");
        for (int i = 1; i <= 22; i++)
            step(0, 1, 32'hD000_0000 + 32'(i), 16'(i), "R1 after reset");
        step(0, 0, 0, 0, "flush");
        step(0, 0, 0, 0, "flush");
        step(0, 0, 0, 0, "flush");
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule